// File: doc/BRIEF.md
# Reduced-Round Wide-State Mixing Round

This block applies one round of a message-less, BLAKE2b-style mixing permutation to a 1024-bit state. The state is handled as sixteen 64-bit words. A round is two passes. Each pass applies four mixing functions side by side. The first pass works on column groups of words, and the second pass works on diagonal groups. No message words and no constants are mixed in. The last rotation of each mixing function is by 63 bits.

The block is meant to sit inside a sponge-style hashing datapath. A controller outside the block feeds the state back through it once per round, and that controller owns round counting, absorb/squeeze handling and memory.

The parameter `PIPELINED` picks between two forms:

- With `PIPELINED = 0`, the whole round is combinational logic in front of a single register. A result is produced one clock after its input.
- With `PIPELINED = 1`, the round is cut into eight register stages, one per half-step of a mixing pass. A result is produced eight clocks after its input, and a new state can be accepted on every clock.

In both forms the valid flag travels in step with the data.

Top module: `lyra_rnd_core`

## Requirements
- R1: Word i of the state occupies bits [64*i+63 : 64*i] of `in_state` and of `out_state`, for i = 0..15.
- R2: The mixing function on words (a,b,c,d) performs, in order: a=a+b; d=ror(d^a,32); c=c+d; b=ror(b^c,24); a=a+b; d=ror(d^a,16); c=c+d; b=ror(b^c,63). All additions are modulo 2^64, and ror is a rotate right.
- R3: The first pass applies the mixing function to the word groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15), each taken as (a,b,c,d).
- R4: The second pass runs on the result of the first pass, over the groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14).
- R5: `out_valid` rises exactly LAT clocks after a clock edge that sampled `in_valid` high, where LAT is 1 when `PIPELINED=0` and 8 when `PIPELINED=1`. In that cycle `out_state` equals one round applied to the sampled `in_state`.
- R6: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_state` is all zeros. A reset in the middle of operation discards every state in flight.
- R7: An all-zero input state yields an all-zero output state, because no constants are injected.
- R8: With `PIPELINED=1`, states presented on consecutive clocks each produce their own correct result. The results come out on consecutive clocks, in input order.
- R9: A clock edge with `in_valid` low produces `out_valid` low LAT clocks later, whatever the value of `in_state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_state` on this edge |
| in_state | input | 1024 | State entering the round, word i at bits 64i+63..64i |
| out_valid | output | 1 | Qualifies `out_state` |
| out_state | output | 1024 | State after one round, same word layout |

## Verification
Every result is due a fixed number of edges after the edge that samples its input: one edge for the iterative form and eight for the pipelined form. The bench therefore keeps, for each form, a queue of expected results preloaded with LAT-1 reset entries. On every rising edge it pushes the reference round of the current input and pops the front entry, and it compares the popped entry with the outputs one time unit after that same edge. The state is compared only when the expected valid is high. The valid flag is compared on every cycle, including bubbles and the cycles right after reset.

// File: rtl/lyra_rnd_pkg.sv
package lyra_rnd_pkg;

    localparam int WORD_W   = 64;
    localparam int NWORDS   = 16;
    localparam int STATE_W  = WORD_W * NWORDS;
    localparam int NGROUPS  = 4;
    localparam int NSTEPS   = 8;   // half-steps per round (4 per pass)

    typedef logic [WORD_W-1:0]             word_t;
    typedef logic [NWORDS-1:0][WORD_W-1:0] state_t;

    typedef struct packed {
        logic   vld;
        state_t st;
    } stage_t;

    // Word index of member k (0=a,1=b,2=c,3=d) of group j in a pass.
    // Pass 0 takes columns, pass 1 takes diagonals.
    function automatic int grp_idx(input int pass, input int j, input int k);
        int lane;
        lane = (pass == 0) ? j : ((j + k) % NGROUPS);
        return k * NGROUPS + lane;
    endfunction

    // Rotation used by quarter q of a mixing function.
    function automatic int rot_amt(input int q);
        case (q)
            0:       return 32;
            1:       return 24;
            2:       return 16;
            default: return 63;
        endcase
    endfunction

    function automatic word_t rotr(input word_t v, input int r);
        return (v >> r) | (v << (WORD_W - r));
    endfunction

endpackage

// File: rtl/lyra_rnd_step.sv
// One quarter of a mixing pass, applied to all four groups at once.
// Even quarters: a += b; d = ror(d ^ a).  Odd quarters: c += d; b = ror(b ^ c).
module lyra_rnd_step
    import lyra_rnd_pkg::*;
#(
    parameter int STEP = 0
) (
    input  state_t st_i,
    output state_t st_o
);
    localparam int PASS = STEP / 4;
    localparam int QTR  = STEP % 4;
    localparam int ROT  = rot_amt(QTR);
    // Roles: x accumulates y, then z is xored with x and rotated.
    localparam int KX = (QTR % 2 == 0) ? 0 : 2;
    localparam int KY = (QTR % 2 == 0) ? 1 : 3;
    localparam int KZ = (QTR % 2 == 0) ? 3 : 1;

    always_comb begin
        st_o = st_i;
        for (int j = 0; j < NGROUPS; j++) begin
            word_t x_d;
            x_d = st_i[grp_idx(PASS, j, KX)] + st_i[grp_idx(PASS, j, KY)];
            st_o[grp_idx(PASS, j, KX)] = x_d;
            st_o[grp_idx(PASS, j, KZ)] = rotr(st_i[grp_idx(PASS, j, KZ)] ^ x_d, ROT);
        end
    end

endmodule

// File: rtl/lyra_rnd_stage.sv
// A half-step plus an optional register carrying state and valid.
module lyra_rnd_stage
    import lyra_rnd_pkg::*;
#(
    parameter int STEP = 0,
    parameter bit REG  = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t stg_i,
    output stage_t stg_o
);
    state_t mix;
    stage_t stg_d;

    lyra_rnd_step #(.STEP(STEP)) u_step (
        .st_i (stg_i.st),
        .st_o (mix)
    );

    always_comb begin
        stg_d     = stg_i;
        stg_d.st  = mix;
    end

    generate
        if (REG) begin : g_reg
            stage_t stg_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= stg_d;
                end
            end
            assign stg_o = stg_q;
        end else begin : g_comb
            assign stg_o = stg_d;
        end
    endgenerate

endmodule

// File: rtl/lyra_rnd_core.sv
module lyra_rnd_core
    import lyra_rnd_pkg::*;
#(
    parameter bit PIPELINED = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] in_state,
    output logic               out_valid,
    output logic [STATE_W-1:0] out_state
);
    localparam int LAT = PIPELINED ? NSTEPS : 1;

    stage_t chain [NSTEPS+1];

    always_comb begin
        chain[0].vld = in_valid;
        chain[0].st  = state_t'(in_state);
    end

    generate
        for (genvar s = 0; s < NSTEPS; s++) begin : g_stage
            localparam bit HAS_REG = PIPELINED || (s == NSTEPS - 1);
            lyra_rnd_stage #(
                .STEP (s),
                .REG  (HAS_REG)
            ) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .stg_i (chain[s]),
                .stg_o (chain[s+1])
            );
        end
    endgenerate

    assign out_valid = chain[NSTEPS].vld;
    assign out_state = chain[NSTEPS].st;

endmodule

// File: rtl/lyra_rnd_chk.sv
module lyra_rnd_chk
    import lyra_rnd_pkg::*;
#(
    parameter bit PIPELINED = 1'b0
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [STATE_W-1:0] in_state,
    input logic               out_valid,
    input logic [STATE_W-1:0] out_state
);
    localparam int LAT = PIPELINED ? NSTEPS : 1;

    logic [LAT:0] vh_q;
    logic [LAT:0] zh_q;
    logic         rst_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vh_q       <= '0;
            zh_q       <= '0;
            rst_seen_q <= 1'b1;
        end else begin
            vh_q <= {vh_q[LAT-1:0], in_valid};
            zh_q <= {zh_q[LAT-1:0], in_valid && (in_state == '0)};
        end
    end

    // R5 / R9: valid emerges exactly LAT edges after the input edge.
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> (out_valid == vh_q[LAT-1]));

    // R6: first cycle after reset release carries no valid.
    a_r6_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_state == '0));

    // R7: zero state maps to zero state.
    a_r7_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen_q && zh_q[LAT-1]) |-> (out_state == '0));

    // R5: a qualified result is never unknown.
    a_r5_known_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_state));

endmodule

bind lyra_rnd_core lyra_rnd_chk #(.PIPELINED(PIPELINED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_state  (in_state),
    .out_valid (out_valid),
    .out_state (out_state)
);

// File: tb/tb_lyra_rnd_core.sv
module tb_lyra_rnd_core;
    localparam int CLK_P = 10;
    localparam int SW    = 1024;

    typedef struct packed {
        logic          v;
        logic [SW-1:0] s;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_state = '0;
    logic          ov_p, ov_i;
    logic [SW-1:0] os_p, os_i;

    int errors = 0;
    int checks = 0;
    string tag = "R6";
    exp_t qp[$];
    exp_t qi[$];

    always #(CLK_P/2) clk = ~clk;

    lyra_rnd_core #(.PIPELINED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
        .out_valid(ov_p), .out_state(os_p));

    lyra_rnd_core #(.PIPELINED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_state(in_state),
        .out_valid(ov_i), .out_state(os_i));

    function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    // Behavioural reference of one round (R2, R3, R4).
    function automatic logic [SW-1:0] ref_round(input logic [SW-1:0] s);
        logic [63:0] w [16];
        logic [SW-1:0] r;
        for (int i = 0; i < 16; i++) w[i] = s[64*i +: 64];
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < 4; j++) begin
                int ia, ib, ic, id;
                ia = j;
                ib = 4  + (p == 0 ? j : (j + 1) % 4);
                ic = 8  + (p == 0 ? j : (j + 2) % 4);
                id = 12 + (p == 0 ? j : (j + 3) % 4);
                w[ia] = w[ia] + w[ib]; w[id] = ror64(w[id] ^ w[ia], 32);
                w[ic] = w[ic] + w[id]; w[ib] = ror64(w[ib] ^ w[ic], 24);
                w[ia] = w[ia] + w[ib]; w[id] = ror64(w[id] ^ w[ia], 16);
                w[ic] = w[ic] + w[id]; w[ib] = ror64(w[ib] ^ w[ic], 63);
            end
        end
        for (int i = 0; i < 16; i++) r[64*i +: 64] = w[i];
        return r;
    endfunction

    function automatic logic [SW-1:0] rnd_state();
        logic [SW-1:0] r;
        for (int i = 0; i < 32; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic check_out(input string nm, input exp_t e,
                             input logic av, input logic [SW-1:0] as);
        checks++;
        if (av !== e.v) begin
            errors++;
            $display("FAIL %s %s valid: actual=%0b expected=%0b", tag, nm, av, e.v);
        end else if (e.v) begin
            checks++;
            if (as !== e.s) begin
                errors++;
                $display("FAIL %s %s state: actual=%h expected=%h", tag, nm, as, e.s);
            end
        end
    endtask

    task automatic reset_queues();
        qp.delete(); qi.delete();
        for (int k = 0; k < 7; k++) qp.push_back('0);
    endtask

    // Drive at negedge, model at posedge, compare one unit later.
    task automatic cyc(input logic v, input logic [SW-1:0] s);
        exp_t e;
        in_valid = v;
        in_state = s;
        @(posedge clk);
        e.v = v;
        e.s = ref_round(s);
        qp.push_back(e);
        qi.push_back(e);
        #1;
        check_out("pipe", qp.pop_front(), ov_p, os_p);
        check_out("iter", qi.pop_front(), ov_i, os_i);
        @(negedge clk);
    endtask

    task automatic drain();
        for (int k = 0; k < 9; k++) cyc(1'b0, rnd_state());
    endtask

    task automatic check_reset_state();
        checks += 2;
        if (ov_p !== 1'b0 || os_p !== '0) begin
            errors++;
            $display("FAIL R6 pipe reset: actual v=%0b s=%h expected 0", ov_p, os_p);
        end
        if (ov_i !== 1'b0 || os_i !== '0) begin
            errors++;
            $display("FAIL R6 iter reset: actual v=%0b s=%h expected 0", ov_i, os_i);
        end
    endtask

    initial begin
        #(CLK_P * 60000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R6: reset state
        tag = "R6";
        in_state = rnd_state();
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state();
        in_valid = 1'b0;
        rst_n = 1'b1;
        reset_queues();
        cyc(1'b0, '0);

        // R7: zero state gives zero state
        tag = "R7";
        cyc(1'b1, '0);
        drain();

        // R1: one nonzero word at each position
        tag = "R1";
        for (int i = 0; i < 16; i++) begin
            logic [SW-1:0] s;
            s = '0;
            s[64*i +: 64] = 64'h0123_4567_89AB_CDEF ^ 64'(i);
            cyc(1'b1, s);
        end
        drain();

        // R2: carry and rotation corner values in one group
        tag = "R2";
        begin
            logic [SW-1:0] s;
            s = '0;
            s[64*0 +: 64]  = '1;
            s[64*4 +: 64]  = 64'h1;
            s[64*8 +: 64]  = 64'h8000_0000_0000_0000;
            s[64*12 +: 64] = 64'hFFFF_0000_FFFF_0000;
            cyc(1'b1, s);
            s = '1;
            cyc(1'b1, s);
        end
        drain();

        // R3: a single column group loaded, others zero
        tag = "R3";
        for (int j = 0; j < 4; j++) begin
            logic [SW-1:0] s;
            s = '0;
            for (int k = 0; k < 4; k++) s[64*(4*k+j) +: 64] = {$urandom, $urandom};
            cyc(1'b1, s);
        end
        drain();

        // R4: a single diagonal group loaded
        tag = "R4";
        for (int j = 0; j < 4; j++) begin
            logic [SW-1:0] s;
            s = '0;
            for (int k = 0; k < 4; k++) s[64*(4*k+(j+k)%4) +: 64] = {$urandom, $urandom};
            cyc(1'b1, s);
        end
        drain();

        // R5: isolated valid inputs
        tag = "R5";
        for (int n = 0; n < 6; n++) begin
            cyc(1'b1, rnd_state());
            for (int g = 0; g < n + 1; g++) cyc(1'b0, rnd_state());
        end
        drain();

        // R8: back-to-back stream
        tag = "R8";
        for (int n = 0; n < 200; n++) cyc(1'b1, rnd_state());
        drain();

        // R9: bubbles with random data
        tag = "R9";
        for (int n = 0; n < 200; n++) cyc(($urandom % 3) == 0, rnd_state());
        drain();

        // R6: reset mid-stream discards work in flight
        tag = "R6";
        for (int n = 0; n < 5; n++) cyc(1'b1, rnd_state());
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk); #1;
        check_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        reset_queues();
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule